// File: doc/BRIEF.md
# Masked-Compare Memory Bank Mapper

This block translates the 16-bit address of an 8-bit processor into a 19-bit address for a 512KB static RAM. A programmable window is picked out of the processor's address space by a 5-bit mask and a 5-bit base value. Both apply to processor address bits A15..A11. Any address whose masked high bits equal the masked base falls inside the window. For those addresses the block raises a `banked` flag and takes the upper SRAM address bits from a bank register. Every other address passes through unchanged, with zeros in the three extra SRAM bits.

The mask controls two things at once: the size of the window and which high bits are replaced. One datapath therefore covers windows from 2KB (mask 0x1F) through 4KB (0x1E), 8KB (0x1C) and 16KB (0x18) up to 32KB (0x10). Software loads the mask, base and bank registers through a small register-write port. A separate one-cycle trigger, meant to be pulsed on a write to a chosen I/O location, loads a fixed alternate bank value. With the reset settings, this swaps the low 8KB window away from SRAM page 0 and onto SRAM 0x10000.

The translation path is purely combinational, so it adds no wait states. Only the configuration registers are clocked.

Top module: `bank_mapper`

## Requirements
- R1: After a synchronous reset the mask is 0x1C, the base is 0x00 and the bank register is 0x00. Processor address 0x1234 then maps to SRAM 0x01234 with `banked` high, and 0x2000 maps to 0x02000 with `banked` low.
- R2: SRAM address bits A10..A0 always equal processor address bits A10..A0.
- R3: `banked` is high exactly when, for every bit i in 0..4 with mask bit i set, processor bit A(11+i) equals base bit i. Base bits under a cleared mask bit have no effect.
- R4: While `banked` is high, SRAM bit A(11+i) for i in 0..4 takes bank bit i where mask bit i is set, and processor bit A(11+i) where it is clear. SRAM A18..A16 take bank bits 7..5.
- R5: While `banked` is low, SRAM A18..A16 are 0 and SRAM A15..A11 equal processor A15..A11.
- R6: A write with `reg_we` high at a rising clock edge updates one register, chosen by `reg_sel`: 0 loads the mask from `reg_wdata[4:0]`, 1 loads the base from `reg_wdata[4:0]`, and 2 loads the bank register from `reg_wdata[7:0]`. The new value governs the mapping from the cycle after that edge.
- R7: A write with `reg_sel` = 3 changes no register.
- R8: A rising edge with `swap_we` high loads the bank register with 0x20. Under the reset mask and base, processor 0x1ABC then maps to SRAM 0x11ABC.
- R9: If `swap_we` and a bank-register write coincide, the bank register takes 0x20.
- R10: The mapping is combinational. A change of `cpu_addr` shows on `sram_addr` and `banked` in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address bus |
| reg_we | input | 1 | Configuration register write strobe |
| reg_sel | input | 2 | Register select: 0 mask, 1 base, 2 bank, 3 reserved |
| reg_wdata | input | 8 | Configuration write data |
| swap_we | input | 1 | Swap trigger, loads the alternate bank |
| sram_addr | output | 19 | Translated SRAM address |
| banked | output | 1 | High while cpu_addr lies inside the window |

## Verification
Address translation has zero latency. The bench changes `cpu_addr` away from the clock edge and samples `sram_addr` and `banked` one nanosecond later, with no edge in between. Register writes and the swap trigger take effect at exactly one rising edge. The bench drives them at a falling edge, drops them at the next falling edge, and only then applies the probe addresses, so every check sees the state one edge after the stimulus. Expected SRAM addresses are computed by hand from the mask, base and bank rules rather than read from the design.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    localparam int CPU_AW  = 16;
    localparam int SRAM_AW = 19;
    localparam int FIELD_W = 5;
    localparam int LOW_W   = CPU_AW - FIELD_W;
    localparam int EXT_W   = SRAM_AW - CPU_AW;
    localparam int BANK_W  = FIELD_W + EXT_W;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_BASE = 2'd1,
        SEL_BANK = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [FIELD_W-1:0] mask;
        logic [FIELD_W-1:0] base;
        logic [BANK_W-1:0]  bank;
    } map_cfg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [LOW_W-1:0]   lo;
    } cpu_addr_t;

    function automatic logic field_hit(
        input logic [FIELD_W-1:0] hi,
        input logic [FIELD_W-1:0] mask,
        input logic [FIELD_W-1:0] base
    );
        return ((hi ^ base) & mask) == '0;
    endfunction

endpackage

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
    import bank_mapper_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_MASK  = 5'h1C,
    parameter logic [FIELD_W-1:0] RST_BASE  = 5'h00,
    parameter logic [BANK_W-1:0]  RST_BANK  = 8'h00,
    parameter logic [BANK_W-1:0]  SWAP_BANK = 8'h20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        swap_we,
    output map_cfg_t    cfg_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mask <= RST_MASK;
            cfg_q.base <= RST_BASE;
            cfg_q.bank <= RST_BANK;
        end else begin
            if (reg_we) begin
                case (sel)
                    SEL_MASK: cfg_q.mask <= reg_wdata[FIELD_W-1:0];
                    SEL_BASE: cfg_q.base <= reg_wdata[FIELD_W-1:0];
                    SEL_BANK: cfg_q.bank <= reg_wdata[BANK_W-1:0];
                    default:  ;
                endcase
            end
            // The swap trigger is last so it wins over a bank write
            if (swap_we) begin
                cfg_q.bank <= SWAP_BANK;
            end
        end
    end

endmodule

// File: rtl/bank_mapper_window.sv
module bank_mapper_window
    import bank_mapper_pkg::*;
(
    input  logic [FIELD_W-1:0] cpu_hi,
    input  logic [FIELD_W-1:0] mask,
    input  logic [FIELD_W-1:0] base,
    output logic               hit
);

    always_comb begin
        hit = field_hit(cpu_hi, mask, base);
    end

endmodule

// File: rtl/bank_mapper_xlate.sv
module bank_mapper_xlate
    import bank_mapper_pkg::*;
(
    input  cpu_addr_t           cpu,
    input  logic                hit,
    input  logic [FIELD_W-1:0]  mask,
    input  logic [BANK_W-1:0]   bank,
    output logic [SRAM_AW-1:0]  sram_addr
);

    logic [FIELD_W-1:0] hi_out;
    logic [EXT_W-1:0]   ext_out;

    // One two-input selector per maskable address bit
    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit_mux
        always_comb begin
            if (hit && mask[i]) begin
                hi_out[i] = bank[i];
            end else begin
                hi_out[i] = cpu.hi[i];
            end
        end
    end

    always_comb begin
        ext_out = hit ? bank[BANK_W-1:FIELD_W] : '0;
    end

    assign sram_addr = {ext_out, hi_out, cpu.lo};

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_MASK  = 5'h1C,
    parameter logic [FIELD_W-1:0] RST_BASE  = 5'h00,
    parameter logic [BANK_W-1:0]  RST_BANK  = 8'h00,
    parameter logic [BANK_W-1:0]  SWAP_BANK = 8'h20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [7:0]          reg_wdata,
    input  logic                swap_we,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic                banked
);

    map_cfg_t  cfg_q;
    cpu_addr_t cpu;

    assign cpu = cpu_addr_t'(cpu_addr);

    bank_mapper_regs #(
        .RST_MASK  (RST_MASK),
        .RST_BASE  (RST_BASE),
        .RST_BANK  (RST_BANK),
        .SWAP_BANK (SWAP_BANK)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .swap_we   (swap_we),
        .cfg_q     (cfg_q)
    );

    bank_mapper_window u_window (
        .cpu_hi (cpu.hi),
        .mask   (cfg_q.mask),
        .base   (cfg_q.base),
        .hit    (banked)
    );

    bank_mapper_xlate u_xlate (
        .cpu       (cpu),
        .hit       (banked),
        .mask      (cfg_q.mask),
        .bank      (cfg_q.bank),
        .sram_addr (sram_addr)
    );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
    import bank_mapper_pkg::*;
#(
    parameter logic [BANK_W-1:0] SWAP_BANK = 8'h20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CPU_AW-1:0]   cpu_addr,
    input  logic [SRAM_AW-1:0]  sram_addr,
    input  logic                banked,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic                swap_we,
    input  logic [FIELD_W-1:0]  mask_q,
    input  logic [FIELD_W-1:0]  base_q,
    input  logic [BANK_W-1:0]   bank_q
);

    p_low_pass_r2: assert property (@(posedge clk) disable iff (rst)
        sram_addr[LOW_W-1:0] == cpu_addr[LOW_W-1:0]);

    p_window_match_r3: assert property (@(posedge clk) disable iff (rst)
        banked |-> ((cpu_addr[CPU_AW-1:LOW_W] ^ base_q) & mask_q) == '0);

    p_ext_bits_r4: assert property (@(posedge clk) disable iff (rst)
        banked |-> sram_addr[SRAM_AW-1:CPU_AW] == bank_q[BANK_W-1:FIELD_W]);

    p_masked_bits_r4: assert property (@(posedge clk) disable iff (rst)
        banked |-> ((sram_addr[CPU_AW-1:LOW_W] ^ bank_q[FIELD_W-1:0]) & mask_q) == '0);

    p_unbanked_pass_r5: assert property (@(posedge clk) disable iff (rst)
        !banked |-> (sram_addr[SRAM_AW-1:CPU_AW] == '0 &&
                     sram_addr[CPU_AW-1:LOW_W] == cpu_addr[CPU_AW-1:LOW_W]));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && !swap_we) |=> ($stable(mask_q) && $stable(base_q) && $stable(bank_q)));

    p_reserved_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 2'd3 && !swap_we) |=>
            ($stable(mask_q) && $stable(base_q) && $stable(bank_q)));

    p_swap_load_r8: assert property (@(posedge clk) disable iff (rst)
        swap_we |=> bank_q == SWAP_BANK);

endmodule

bind bank_mapper bank_mapper_chk #(
    .SWAP_BANK (SWAP_BANK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .sram_addr (sram_addr),
    .banked    (banked),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .swap_we   (swap_we),
    .mask_q    (cfg_q.mask),
    .base_q    (cfg_q.base),
    .bank_q    (cfg_q.bank)
);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        swap_we = 1'b0;
    logic [18:0] sram_addr;
    logic        banked;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bank_mapper u_bank_mapper (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .swap_we   (swap_we),
        .sram_addr (sram_addr),
        .banked    (banked)
    );

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%05h expected 0x%05h", req, got, exp);
        end
    endtask

    // Apply an address between edges and check the combinational result
    task automatic probe(input string req, input logic [15:0] a,
                         input logic [18:0] exp_sram, input logic exp_bk);
        cpu_addr = a;
        #1;
        check(req, {1'b0, sram_addr}, {1'b0, exp_sram});
        check(req, {19'd0, banked}, {19'd0, exp_bk});
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data, input logic swp);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel;
        reg_wdata = data;
        swap_we = swp;
        @(negedge clk);
        reg_we = 1'b0;
        swap_we = 1'b0;
    endtask

    task automatic swap_only();
        @(negedge clk);
        swap_we = 1'b1;
        @(negedge clk);
        swap_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_map();
        do_reset();
        probe("R1", 16'h1234, 19'h01234, 1'b1);
        probe("R1", 16'h2000, 19'h02000, 1'b0);
        probe("R2", 16'hFFFF, 19'h0FFFF, 1'b0);
        probe("R5", 16'hA7C3, 19'h0A7C3, 1'b0);
    endtask

    task automatic t_comb_timing();
        // R10: two address changes inside one clock phase
        @(negedge clk);
        probe("R10", 16'h0001, 19'h00001, 1'b1);
        probe("R10", 16'h4001, 19'h04001, 1'b0);
    endtask

    task automatic t_swap();
        swap_only();
        probe("R8", 16'h1ABC, 19'h11ABC, 1'b1);
        probe("R8", 16'h0000, 19'h10000, 1'b1);
        probe("R5", 16'h2ABC, 19'h02ABC, 1'b0);
    endtask

    task automatic t_two_k_window();
        wr(2'd0, 8'h1F, 1'b0);
        wr(2'd1, 8'h05, 1'b0);
        wr(2'd2, 8'hFF, 1'b0);
        probe("R6", 16'h2C01, 19'h7FC01, 1'b1);
        probe("R3", 16'h3001, 19'h03001, 1'b0);
        probe("R2", 16'h2FFF, 19'h7FFFF, 1'b1);
    endtask

    task automatic t_big_windows();
        wr(2'd0, 8'h10, 1'b0);
        wr(2'd1, 8'h1F, 1'b0);
        wr(2'd2, 8'h5A, 1'b0);
        // R3: base bits under cleared mask bits are ignored
        probe("R3", 16'h8000, 19'h28000, 1'b1);
        probe("R4", 16'h9234, 19'h29234, 1'b1);
        probe("R5", 16'h7FFF, 19'h07FFF, 1'b0);
        wr(2'd0, 8'h18, 1'b0);
        wr(2'd1, 8'h08, 1'b0);
        probe("R4", 16'h5555, 19'h2D555, 1'b1);
        probe("R3", 16'h8555, 19'h08555, 1'b0);
    endtask

    task automatic t_reserved();
        do_reset();
        wr(2'd3, 8'hFF, 1'b0);
        probe("R7", 16'h1234, 19'h01234, 1'b1);
        probe("R7", 16'h2000, 19'h02000, 1'b0);
    endtask

    task automatic t_priority();
        wr(2'd2, 8'hE0, 1'b1);
        probe("R9", 16'h0000, 19'h10000, 1'b1);
        wr(2'd2, 8'hE0, 1'b0);
        probe("R6", 16'h0000, 19'h70000, 1'b1);
    endtask

    task automatic t_reset_restore();
        do_reset();
        probe("R1", 16'h1FFF, 19'h01FFF, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_map();
        t_comb_timing();
        t_swap();
        t_two_k_window();
        t_big_windows();
        t_reserved();
        t_priority();
        t_reset_restore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule